// File: doc/BRIEF.md
# Latch-framed serial command receiver

This block is the command front end of a multiplexed LED sink driver. A controller sends data over three wires: a serial clock, a serial data input and a latch strobe. Each bit enters a 16-bit shift register. The register's top bit drives a serial output, so several drivers can be chained with each output feeding the next input. A single 16-bit register serves both for writing into the driver and for reading back from it.

The command is given by how many serial-clock rising edges occur while the latch is held high. The falling edge of the latch carries the command out. A grayscale write sends the shift register contents to the frame memory at an address that advances on its own. A frame sync pulses a strobe and returns that address to its start. A control write loads the function control register. Two read commands fill the shift register with either the control word or the open-LED status word, and the controller then clocks that word out. A latch frame with any other edge count changes nothing.

All pins are sampled on a fast system clock, and edges are found by comparing each pin with its value one cycle earlier.

Top module: `lat_cmd_rx`

## Requirements
- R1: On each detected rising edge of `ser_clk`, the shift register moves one place toward its MSB and `ser_din` enters bit 0.
- R2: `ser_dout` always shows bit 15 of the shift register. A word shifted in with the latch low therefore comes out MSB first after 16 more rising edges.
- R3: A latch frame with exactly 1 rising edge raises `gs_wr` for one cycle. `gs_data` then holds the 16-bit shift register contents.
- R4: Grayscale writes carry an address that starts at channel 0, line 0. The channel advances first. After channel CH-1 the channel returns to 0 and the line advances. After channel CH-1 of line LINES-1 the address returns to channel 0, line 0.
- R5: A latch frame with exactly 3 rising edges raises `frame_sync` for one cycle and returns the grayscale address to channel 0, line 0.
- R6: A latch frame with exactly 11 rising edges loads the control register from the shift register. The layout is: brightness in bits 6:0, open-LED threshold select in bits 8:7, open-LED removal enable in bit 9, power save in bit 10, and dual-edge mode in bit 11. Bits 15:12 always read as zero.
- R7: After reset the shift register and address are zero and no strobe is active. The brightness is 36h, the threshold select is 0, removal enable is 1, and power save and dual-edge mode are 0, so the control word is 0236h.
- R8: A latch frame with exactly 5 rising edges loads the control word into the shift register, ready to be clocked out on `ser_dout`.
- R9: A latch frame with exactly 7 rising edges loads the `open_led` word, as sampled at the latch fall, into the shift register.
- R10: A latch frame with any other count, including 0 and counts of 12 or more, raises no strobe and leaves the control register, the shift register and the grayscale address unchanged.
- R11: `gs_wr` and `frame_sync` are never high together. Each lasts exactly one cycle and only follows a latch fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data input |
| ser_lat | input | 1 | Latch strobe that frames commands |
| open_led | input | DW | Open-LED status word, one bit per channel |
| ser_dout | output | 1 | Serial data output (shift register MSB) |
| gs_wr | output | 1 | Grayscale memory write strobe |
| gs_data | output | DW | Grayscale word to write |
| gs_chan | output | log2(CH) | Channel address of the write |
| gs_line | output | log2(LINES) | Line address of the write |
| frame_sync | output | 1 | Frame sync strobe |
| cfg_bright | output | 7 | Global brightness field |
| cfg_lod_thr | output | 2 | Open-LED threshold select |
| cfg_open_rm | output | 1 | Open-LED removal enable |
| cfg_psave | output | 1 | Power-save enable |
| cfg_dual_edge | output | 1 | Dual-edge grayscale clock mode |

## Verification
The assertions check on every cycle that:
- each sampled clock edge shifts exactly one bit;
- the serial output holds still when there is no edge and no latch fall;
- the two strobes are exclusive single-cycle pulses caused by a latch fall;
- the control register changes only at a latch fall;
- every write address is in range.

Only the bench scenarios can show that each edge count selects the right command. They also show that read-back words come out MSB first, that the address wraps after the last channel of the last line, and that frame sync restarts it. Finally, they show that unrecognised counts leave the shift register, address and control fields untouched.

// File: rtl/lat_cmd_rx.sv
module lat_cmd_rx #(
  parameter int DW         = 16,
  parameter int CH         = 16,
  parameter int LINES      = 48,
  parameter int CNT_GS     = 1,
  parameter int CNT_SYNC   = 3,
  parameter int CNT_RDCTL  = 5,
  parameter int CNT_RDLOD  = 7,
  parameter int CNT_WRCTL  = 11,
  parameter logic [6:0] BRIGHT_RST = 7'h36,
  localparam int CHW = $clog2(CH),
  localparam int LNW = $clog2(LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_lat,
  input  logic [DW-1:0]  open_led,
  output logic           ser_dout,
  output logic           gs_wr,
  output logic [DW-1:0]  gs_data,
  output logic [CHW-1:0] gs_chan,
  output logic [LNW-1:0] gs_line,
  output logic           frame_sync,
  output logic [6:0]     cfg_bright,
  output logic [1:0]     cfg_lod_thr,
  output logic           cfg_open_rm,
  output logic           cfg_psave,
  output logic           cfg_dual_edge
);
  localparam int CW = $clog2(CNT_WRCTL + 2);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] K_GS    = CW'(CNT_GS);
  localparam logic [CW-1:0] K_SYNC  = CW'(CNT_SYNC);
  localparam logic [CW-1:0] K_RDCTL = CW'(CNT_RDCTL);
  localparam logic [CW-1:0] K_RDLOD = CW'(CNT_RDLOD);
  localparam logic [CW-1:0] K_WRCTL = CW'(CNT_WRCTL);
  localparam logic [DW-1:0] CTRL_MASK = DW'(16'h0FFF);
  localparam logic [DW-1:0] CTRL_RST  = DW'({4'h0, 1'b0, 1'b0, 1'b1, 2'b00, BRIGHT_RST});
  localparam logic [CHW-1:0] CH_LAST = CHW'(CH - 1);
  localparam logic [LNW-1:0] LN_LAST = LNW'(LINES - 1);

  logic           sclk_q, lat_q;
  logic [DW-1:0]  shift, ctrl;
  logic [CW-1:0]  cnt;
  logic [CHW-1:0] chan;
  logic [LNW-1:0] line;

  wire sclk_rise = ser_clk & ~sclk_q;
  wire lat_fall  = lat_q & ~ser_lat;

  assign ser_dout      = shift[DW-1];
  assign cfg_bright    = ctrl[6:0];
  assign cfg_lod_thr   = ctrl[8:7];
  assign cfg_open_rm   = ctrl[9];
  assign cfg_psave     = ctrl[10];
  assign cfg_dual_edge = ctrl[11];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      lat_q      <= 1'b0;
      shift      <= '0;
      ctrl       <= CTRL_RST;
      cnt        <= '0;
      chan       <= '0;
      line       <= '0;
      gs_wr      <= 1'b0;
      gs_data    <= '0;
      gs_chan    <= '0;
      gs_line    <= '0;
      frame_sync <= 1'b0;
    end else begin
      sclk_q     <= ser_clk;
      lat_q      <= ser_lat;
      gs_wr      <= 1'b0;
      frame_sync <= 1'b0;
      if (lat_fall) begin
        cnt <= '0;
        if (cnt == K_GS) begin
          gs_wr   <= 1'b1;
          gs_data <= shift;
          gs_chan <= chan;
          gs_line <= line;
          if (chan == CH_LAST) begin
            chan <= '0;
            line <= (line == LN_LAST) ? '0 : line + 1'b1;
          end else begin
            chan <= chan + 1'b1;
          end
        end else if (cnt == K_SYNC) begin
          frame_sync <= 1'b1;
          chan       <= '0;
          line       <= '0;
        end else if (cnt == K_WRCTL) begin
          ctrl <= shift & CTRL_MASK;
        end else if (cnt == K_RDCTL) begin
          shift <= ctrl;
        end else if (cnt == K_RDLOD) begin
          shift <= open_led;
        end
      end else if (sclk_rise) begin
        shift <= {shift[DW-2:0], ser_din};
        if (ser_lat && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lat_cmd_rx_chk.sv
module lat_cmd_rx_chk #(
  parameter int DW    = 16,
  parameter int CH    = 16,
  parameter int LINES = 48,
  localparam int CHW = $clog2(CH),
  localparam int LNW = $clog2(LINES)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ser_clk,
  input logic           ser_din,
  input logic           ser_lat,
  input logic           sclk_q,
  input logic           lat_q,
  input logic [DW-1:0]  shift,
  input logic [DW-1:0]  ctrl,
  input logic           ser_dout,
  input logic           gs_wr,
  input logic           frame_sync,
  input logic [CHW-1:0] gs_chan,
  input logic [LNW-1:0] gs_line
);
  a_r1_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !sclk_q && !(lat_q && !ser_lat)) |=>
      shift == {$past(shift[DW-2:0]), $past(ser_din)});

  a_r2_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ser_clk && !sclk_q) && !(lat_q && !ser_lat)) |=> $stable(ser_dout));

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gs_wr, frame_sync}));

  a_r11_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_wr || frame_sync) |-> $past(lat_q && !ser_lat));

  a_r11_single_gs: assert property (@(posedge clk) disable iff (!rst_n)
    gs_wr |=> !gs_wr);

  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_q && !ser_lat) |=> $stable(ctrl));

  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    gs_wr |-> (int'(gs_chan) < CH && int'(gs_line) < LINES));
endmodule

bind lat_cmd_rx lat_cmd_rx_chk #(.DW(DW), .CH(CH), .LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
  .ser_lat(ser_lat), .sclk_q(sclk_q), .lat_q(lat_q), .shift(shift),
  .ctrl(ctrl), .ser_dout(ser_dout), .gs_wr(gs_wr),
  .frame_sync(frame_sync), .gs_chan(gs_chan), .gs_line(gs_line)
);

// File: tb/lat_cmd_rx_tb_top.sv
module lat_cmd_rx_tb_top;
  localparam int CH = 16;
  localparam int L  = 3;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, ser_lat = 0;
  logic [15:0] open_led = '0;
  logic ser_dout, gs_wr, frame_sync, cfg_open_rm, cfg_psave, cfg_dual_edge;
  logic [15:0] gs_data;
  logic [3:0] gs_chan;
  logic [1:0] gs_line;
  logic [6:0] cfg_bright;
  logic [1:0] cfg_lod_thr;

  int tests = 0, fails = 0, cyc = 0;
  int gs_n = 0, fs_n = 0;
  logic [15:0] last_data;
  int last_ch, last_ln;
  int exp_ch = 0, exp_ln = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lat_cmd_rx #(.CH(CH), .LINES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_lat(ser_lat), .open_led(open_led), .ser_dout(ser_dout),
    .gs_wr(gs_wr), .gs_data(gs_data), .gs_chan(gs_chan), .gs_line(gs_line),
    .frame_sync(frame_sync), .cfg_bright(cfg_bright), .cfg_lod_thr(cfg_lod_thr),
    .cfg_open_rm(cfg_open_rm), .cfg_psave(cfg_psave), .cfg_dual_edge(cfg_dual_edge)
  );

  always @(negedge clk) begin
    if (gs_wr) begin
      gs_n++; last_data = gs_data; last_ch = int'(gs_chan); last_ln = int'(gs_line);
    end
    if (frame_sync) fs_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_pulse(input logic b);
    @(negedge clk) ser_din = b;
    @(negedge clk) ser_clk = 1;
    @(negedge clk);
    @(negedge clk) ser_clk = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n);
    for (int i = 15; i >= 0; i--) begin
      if (n > 0 && i == n - 1) @(negedge clk) ser_lat = 1;
      bit_pulse(w[i]);
    end
    if (n == 0) begin
      @(negedge clk) ser_lat = 1;
      @(negedge clk);
    end
    @(negedge clk) ser_lat = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_in(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) bit_pulse(w[i]);
  endtask

  task automatic read16(output logic [15:0] r);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk) r[i] = ser_dout;
      bit_pulse(1'b0);
    end
  endtask

  task automatic gs_write(input logic [15:0] v, input bit chk);
    int n0;
    n0 = gs_n;
    send(v, 1);
    if (chk) begin
      check("R11 one gs_wr pulse per write", 32'(gs_n - n0), 32'd1);
      check("R3 gs_data", 32'(last_data), 32'(v));
      check("R4 channel address", 32'(last_ch), 32'(exp_ch));
      check("R4 line address", 32'(last_ln), 32'(exp_ln));
    end
    if (exp_ch == CH - 1) begin
      exp_ch = 0;
      exp_ln = (exp_ln == L - 1) ? 0 : exp_ln + 1;
    end else exp_ch++;
  endtask

  localparam logic [15:0] GS_VEC [6] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'hA5A5, 16'h7FFE};
  localparam int BAD_CNT [4] = '{0, 2, 4, 13};

  initial begin
    logic [15:0] r;
    logic [15:0] cw;
    int g0, f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check("R7 ser_dout", 32'(ser_dout), 32'd0);
    check("R7 brightness", 32'(cfg_bright), 32'h36);
    check("R7 threshold", 32'(cfg_lod_thr), 32'd0);
    check("R7 removal enable", 32'(cfg_open_rm), 32'd1);
    check("R7 power save and dual edge", 32'({cfg_psave, cfg_dual_edge}), 32'd0);
    check("R7 no strobes", 32'(gs_wr | frame_sync), 32'd0);

    // R1 R2 cascade pass-through
    shift_in(16'hA5C3);
    read16(r);
    check("R1 R2 cascade shift-out", 32'(r), 32'hA5C3);
    check("R2 no strobe without latch", 32'(gs_n + fs_n), 32'd0);

    // R3 R4 table walk
    foreach (GS_VEC[k]) gs_write(GS_VEC[k], 1);

    // R5 frame sync
    g0 = gs_n; f0 = fs_n;
    send(16'h0F0F, 3);
    check("R5 frame_sync pulse", 32'(fs_n - f0), 32'd1);
    check("R5 no gs write on sync", 32'(gs_n - g0), 32'd0);
    exp_ch = 0; exp_ln = 0;
    gs_write(16'h4321, 1);

    // R6 control write
    cw = 16'hF5A3;
    send(cw, 11);
    check("R6 brightness", 32'(cfg_bright), 32'(cw[6:0]));
    check("R6 threshold", 32'(cfg_lod_thr), 32'(cw[8:7]));
    check("R6 removal enable", 32'(cfg_open_rm), 32'(cw[9]));
    check("R6 power save", 32'(cfg_psave), 32'(cw[10]));
    check("R6 dual edge", 32'(cfg_dual_edge), 32'(cw[11]));

    // R8 control readback
    send(16'h0000, 5);
    read16(r);
    check("R8 R6 control readback", 32'(r), 32'h05A3);

    // R9 open-LED readback
    open_led = 16'hBEEF;
    send(16'h0000, 7);
    open_led = 16'h0000;
    read16(r);
    check("R9 open-LED readback", 32'(r), 32'hBEEF);

    // R10 ignored counts
    foreach (BAD_CNT[k]) begin
      g0 = gs_n; f0 = fs_n;
      send(16'h6C00 + 16'(k), BAD_CNT[k]);
      check("R10 no strobe", 32'((gs_n - g0) + (fs_n - f0)), 32'd0);
      check("R10 control unchanged", 32'({cfg_dual_edge, cfg_psave, cfg_open_rm, cfg_lod_thr, cfg_bright}), 32'h5A3);
      read16(r);
      check("R10 shift register unchanged", 32'(r), 32'(16'h6C00 + 16'(k)));
    end
    gs_write(16'h0BAD, 1);

    // R4 wrap after last channel of last line
    while (!(exp_ch == CH - 1 && exp_ln == L - 1)) gs_write(16'(exp_ch), 0);
    gs_write(16'hCAFE, 1);
    check("R4 last write at final line", 32'(last_ln), 32'(L - 1));
    gs_write(16'hBEAD, 1);
    check("R4 wrap to channel 0", 32'(last_ch), 32'd0);
    check("R4 wrap to line 0", 32'(last_ln), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule